// File: doc/BRIEF.md
# Vector Length Control Register Bank with Access Trap Resolution

This block keeps three small per-privilege-level vector length control registers (one each for levels 1, 2 and 3). For every access it also works out whether the access may go ahead, must trap, or is undefined. A requester presents one read or write per cycle. With the request come the current privilege level, the secure-state flag, a flag telling whether the top level runs in 64-bit mode, and the live values of the three trap-control registers: the level-1 access control register, the level-2 trap register and the level-3 trap register. Two static flags say whether levels 2 and 3 are implemented.

One cycle after each request the block returns a response. The response carries zero-extended read data, a 2-bit trap target code and an undefined flag. The trap target comes from an ordered chain. First the two 2-bit enable fields of the level-1 access control register are checked. Then the level-2 trap bits, then the level-3 trap bits. The first check that fires decides the target. A trap that would go to level 1 is redirected to level 3 in some secure configurations. The register bank only records writes that complete normally.

Top module: `vlen_trap_bank`

## Requirements
- R1: After reset all three length registers hold zero and `rsp_valid` is low.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. `rsp_rdata` is the selected register zero-extended to 64 bits, and it is zero for writes, traps and undefined accesses.
- R3: A completed write stores only bits [3:0] of `req_wdata`. Bits [63:4] of every length register read as zero.
- R4: `req_sel` 1, 2 or 3 picks the level-1, level-2 or level-3 register. The access is undefined (`rsp_undef`=1, `rsp_trap`=0) when `req_sel` is 0, when `cur_lvl` is below `req_sel`, or when `req_sel` is 3 and `has_lvl3` is 0.
- R5: The vector enable field `acc_ctl[17:16]` traps accesses from levels 0 and 1 when it is 0 or 2. It traps only level 0 when it is 1, and traps nothing when it is 3. A hit gives trap target 1.
- R6: Only when the vector enable field does not hit, the FP enable field `acc_ctl[21:20]` is checked with the same encoding and the same target.
- R7: A target-1 trap becomes target 3 when `sec_state`=1 and `top_is_64`=0.
- R8: When no enable field hits, `has_lvl2`=1, `cur_lvl`<=2 and `sec_state`=0, the access traps to 2 if `hyp_trap[8]` or `hyp_trap[10]` is set.
- R9: When no earlier check hits and `has_lvl3`=1, the access traps to 3 if `mon_trap[8]` is clear or `mon_trap[10]` is set.
- R10: `rsp_trap` encodes 0 = completes normally, and 1, 2 or 3 = target level. Checks are evaluated in the order R5, R6, R8, R9, and the first hit decides.
- R11: A trapped or undefined write leaves every length register unchanged.
- R12: With `has_lvl2`=0, a level-2 register access at level 2 or above reads zero, ignores writes and skips the whole trap chain (`rsp_trap`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_lvl | input | 2 | Current privilege level 0..3 |
| sec_state | input | 1 | Core is in secure state |
| top_is_64 | input | 1 | Level 3 runs in 64-bit mode |
| has_lvl2 | input | 1 | Level 2 is implemented |
| has_lvl3 | input | 1 | Level 3 is implemented |
| acc_ctl | input | 64 | Level-1 access control register value |
| hyp_trap | input | 64 | Level-2 trap register value |
| mon_trap | input | 64 | Level-3 trap register value |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 2 | Target register level (1..3) |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_rdata | output | 64 | Zero-extended read data |
| rsp_trap | output | 2 | Trap target code |
| rsp_undef | output | 1 | Access undefined |

## Verification
The assertions assume that the privilege level, security flags and trap-control values are steady within the cycle a request is sampled. They also assume that `has_lvl2` and `has_lvl3` change only between accesses, never in the cycle just before or after one. The bench holds to this by changing configuration only at falling edges with `req_valid` low, and by leaving at least one idle cycle after each reconfiguration. Every access is a single-cycle pulse, and its response is sampled at the following falling edge.

// File: rtl/vlt_pkg.sv
package vlt_pkg;
    typedef enum logic [1:0] {
        TRAP_NONE = 2'd0,
        TRAP_L1   = 2'd1,
        TRAP_L2   = 2'd2,
        TRAP_L3   = 2'd3
    } trap_t;

    typedef struct packed {
        logic        valid;
        logic [63:0] rdata;
        trap_t       trap;
        logic        undef;
    } rsp_t;
endpackage

// File: rtl/vlt_trap_eval.sv
module vlt_trap_eval
    import vlt_pkg::*;
#(
    parameter int NFIELD = 2
) (
    input  logic [1:0]            cur_lvl,
    input  logic                  sec_state,
    input  logic                  top_is_64,
    input  logic                  has_lvl2,
    input  logic                  has_lvl3,
    input  logic [NFIELD-1:0][1:0] en_fields,
    input  logic [1:0]            l2_bits,
    input  logic                  l3_vec_en,
    input  logic                  l3_fp_trap,
    output trap_t                 trap_code
);
    logic [NFIELD-1:0] field_hit;
    trap_t             l1_target;

    function automatic logic field_traps(input logic [1:0] f, input logic [1:0] lvl);
        case (f)
            2'd1:    field_traps = (lvl == 2'd0);
            2'd3:    field_traps = 1'b0;
            default: field_traps = (lvl <= 2'd1);
        endcase
    endfunction

    // Earlier fields have priority; a field is only reached if all before it miss
    for (genvar g = 0; g < NFIELD; g++) begin : g_field
        assign field_hit[g] = field_traps(en_fields[g], cur_lvl);
    end

    always_comb begin
        l1_target = (sec_state && !top_is_64) ? TRAP_L3 : TRAP_L1;
        trap_code = TRAP_NONE;
        if (|field_hit) begin
            trap_code = l1_target;
        end else if (has_lvl2 && (cur_lvl != 2'd3) && !sec_state && (|l2_bits)) begin
            trap_code = TRAP_L2;
        end else if (has_lvl3 && (!l3_vec_en || l3_fp_trap)) begin
            trap_code = TRAP_L3;
        end
    end
endmodule

// File: rtl/vlt_len_regs.sv
module vlt_len_regs #(
    parameter int NREG  = 3,
    parameter int LEN_W = 4,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [LEN_W-1:0]           wr_data,
    output logic [NREG-1:0][LEN_W-1:0] len_q
);
    typedef struct packed {
        logic [NREG-1:0][LEN_W-1:0] len;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NREG; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                state_d.len[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign len_q = state_q.len;
endmodule

// File: rtl/vlen_trap_bank.sv
module vlen_trap_bank
    import vlt_pkg::*;
#(
    parameter int DATA_W      = 64,
    parameter int LEN_W       = 4,
    parameter int VEC_EN_LSB  = 16,
    parameter int FP_EN_LSB   = 20,
    parameter int TRAP_VEC_BIT = 8,
    parameter int TRAP_FP_BIT  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cur_lvl,
    input  logic              sec_state,
    input  logic              top_is_64,
    input  logic              has_lvl2,
    input  logic              has_lvl3,
    input  logic [DATA_W-1:0] acc_ctl,
    input  logic [DATA_W-1:0] hyp_trap,
    input  logic [DATA_W-1:0] mon_trap,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_sel,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [1:0]        rsp_trap,
    output logic              rsp_undef
);
    localparam int NREG   = 3;
    localparam int NFIELD = 2;
    localparam int IDX_W  = $clog2(NREG);

    logic [NFIELD-1:0][1:0]     en_fields;
    logic [1:0]                 l2_bits;
    trap_t                      chain_trap;
    logic [NREG-1:0][LEN_W-1:0] len_q;
    logic [IDX_W-1:0]           idx;
    logic                       undef_c, l2_absent, wr_en;
    trap_t                      trap_c;
    rsp_t                       rsp_d, rsp_q;
    logic                       unused_bits;

    assign unused_bits = ^{acc_ctl, hyp_trap, mon_trap, req_wdata};

    assign en_fields[0] = acc_ctl[VEC_EN_LSB +: 2];
    assign en_fields[1] = acc_ctl[FP_EN_LSB +: 2];
    assign l2_bits      = {hyp_trap[TRAP_FP_BIT], hyp_trap[TRAP_VEC_BIT]};

    vlt_trap_eval #(.NFIELD(NFIELD)) u_eval (
        .cur_lvl    (cur_lvl),
        .sec_state  (sec_state),
        .top_is_64  (top_is_64),
        .has_lvl2   (has_lvl2),
        .has_lvl3   (has_lvl3),
        .en_fields  (en_fields),
        .l2_bits    (l2_bits),
        .l3_vec_en  (mon_trap[TRAP_VEC_BIT]),
        .l3_fp_trap (mon_trap[TRAP_FP_BIT]),
        .trap_code  (chain_trap)
    );

    vlt_len_regs #(.NREG(NREG), .LEN_W(LEN_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (idx),
        .wr_data (req_wdata[LEN_W-1:0]),
        .len_q   (len_q)
    );

    always_comb begin
        idx       = IDX_W'(req_sel - 2'd1);
        undef_c   = (req_sel == 2'd0) || (cur_lvl < req_sel) ||
                    ((req_sel == 2'd3) && !has_lvl3);
        l2_absent = (req_sel == 2'd2) && !has_lvl2;
        trap_c    = (undef_c || l2_absent) ? TRAP_NONE : chain_trap;
        wr_en     = req_valid && req_write && !undef_c && !l2_absent &&
                    (trap_c == TRAP_NONE);

        rsp_d       = '0;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.trap  = trap_c;
            rsp_d.undef = undef_c;
            if (!req_write && !undef_c && !l2_absent && (trap_c == TRAP_NONE)) begin
                rsp_d.rdata = DATA_W'(len_q[idx]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_rdata = rsp_q.rdata;
    assign rsp_trap  = rsp_q.trap;
    assign rsp_undef = rsp_q.undef;

    // R2
    rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R2
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R3
    zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_rdata[DATA_W-1:LEN_W] == '0));
    // R4
    undef_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_undef |-> (rsp_trap == 2'd0 && rsp_rdata == '0));
    // R11
    blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && (undef_c || chain_trap != TRAP_NONE)) |=>
        (len_q == $past(len_q)));
    // R12
    absent_l2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_sel == 2'd2 && cur_lvl >= 2'd2 && !has_lvl2) |=>
        (rsp_trap == 2'd0 && rsp_rdata == '0 && !rsp_undef));
endmodule

// File: tb/vlen_trap_bank_test.sv
module vlen_trap_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cur_lvl = 2'd1;
    logic        sec_state = 1'b0, top_is_64 = 1'b1;
    logic        has_lvl2 = 1'b1, has_lvl3 = 1'b1;
    logic [63:0] acc_ctl = 64'h0033_0000;
    logic [63:0] hyp_trap = 64'h0;
    logic [63:0] mon_trap = 64'h100;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_sel = 2'd1;
    logic [63:0] req_wdata = 64'h0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic [1:0]  rsp_trap;
    logic        rsp_undef;

    int vectors = 0, miscompares = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vlen_trap_bank uut (
        .clk(clk), .rst_n(rst_n), .cur_lvl(cur_lvl), .sec_state(sec_state),
        .top_is_64(top_is_64), .has_lvl2(has_lvl2), .has_lvl3(has_lvl3),
        .acc_ctl(acc_ctl), .hyp_trap(hyp_trap), .mon_trap(mon_trap),
        .req_valid(req_valid), .req_write(req_write), .req_sel(req_sel),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_trap(rsp_trap), .rsp_undef(rsp_undef)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] lvl, input logic sec, input logic t64,
                           input logic [63:0] a, input logic [63:0] h, input logic [63:0] m);
        cur_lvl = lvl; sec_state = sec; top_is_64 = t64;
        acc_ctl = a; hyp_trap = h; mon_trap = m;
    endtask

    // One access: drive at falling edge, response sampled at next falling edge
    task automatic access(input string req, input logic w, input logic [1:0] sel,
                          input logic [63:0] wd, input logic [63:0] exp_rd,
                          input logic [1:0] exp_trap, input logic exp_undef);
        req_valid = 1'b1; req_write = w; req_sel = sel; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " valid"}, {63'd0, rsp_valid}, 64'd1);
        check({req, " rdata"}, rsp_rdata, exp_rd);
        check({req, " trap"}, {62'd0, rsp_trap}, {62'd0, exp_trap});
        check({req, " undef"}, {63'd0, rsp_undef}, {63'd0, exp_undef});
    endtask

    task automatic t_reset;
        check("R1 valid in reset", {63'd0, rsp_valid}, 64'd0);
        set_cfg(2'd3, 1'b0, 1'b1, 64'h0033_0000, 64'h0, 64'h100);
        access("R1 L1 reg", 1'b0, 2'd1, 64'h0, 64'h0, 2'd0, 1'b0);
        access("R1 L2 reg", 1'b0, 2'd2, 64'h0, 64'h0, 2'd0, 1'b0);
        access("R1 L3 reg", 1'b0, 2'd3, 64'h0, 64'h0, 2'd0, 1'b0);
        @(negedge clk);
        check("R2 idle no response", {63'd0, rsp_valid}, 64'd0);
    endtask

    task automatic t_mask;
        set_cfg(2'd3, 1'b0, 1'b1, 64'h0033_0000, 64'h0, 64'h100);
        access("R3 write L1", 1'b1, 2'd1, 64'hFFFF_FFFF_FFFF_FFF5, 64'h0, 2'd0, 1'b0);
        access("R3 read L1", 1'b0, 2'd1, 64'h0, 64'h5, 2'd0, 1'b0);
        access("R3 write L2", 1'b1, 2'd2, 64'hABCD_0000_0000_009A, 64'h0, 2'd0, 1'b0);
        access("R3 write L3", 1'b1, 2'd3, 64'h0000_0000_0000_00F7, 64'h0, 2'd0, 1'b0);
        access("R3 read L2", 1'b0, 2'd2, 64'h0, 64'hA, 2'd0, 1'b0);
        access("R3 read L3", 1'b0, 2'd3, 64'h0, 64'h7, 2'd0, 1'b0);
    endtask

    task automatic t_fields;
        set_cfg(2'd1, 1'b0, 1'b1, 64'h0030_0000, 64'h0, 64'h100);
        access("R5 vec=0 lvl1", 1'b0, 2'd1, 64'h0, 64'h0, 2'd1, 1'b0);
        set_cfg(2'd1, 1'b0, 1'b1, 64'h0032_0000, 64'h0, 64'h100);
        access("R5 vec=2 lvl1", 1'b0, 2'd1, 64'h0, 64'h0, 2'd1, 1'b0);
        set_cfg(2'd1, 1'b0, 1'b1, 64'h0031_0000, 64'h0, 64'h100);
        access("R5 vec=1 lvl1", 1'b0, 2'd1, 64'h0, 64'h5, 2'd0, 1'b0);
        set_cfg(2'd2, 1'b0, 1'b1, 64'h0030_0000, 64'h0, 64'h100);
        access("R5 vec=0 lvl2", 1'b0, 2'd1, 64'h0, 64'h5, 2'd0, 1'b0);
        set_cfg(2'd1, 1'b0, 1'b1, 64'h0003_0000, 64'h0, 64'h100);
        access("R6 fp=0 lvl1", 1'b0, 2'd1, 64'h0, 64'h0, 2'd1, 1'b0);
        set_cfg(2'd1, 1'b0, 1'b1, 64'h0013_0000, 64'h0, 64'h100);
        access("R6 fp=1 lvl1", 1'b0, 2'd1, 64'h0, 64'h5, 2'd0, 1'b0);
    endtask

    task automatic t_secure;
        set_cfg(2'd1, 1'b1, 1'b0, 64'h0030_0000, 64'h0, 64'h100);
        access("R7 redirect", 1'b0, 2'd1, 64'h0, 64'h0, 2'd3, 1'b0);
        set_cfg(2'd1, 1'b1, 1'b1, 64'h0030_0000, 64'h0, 64'h100);
        access("R7 no redirect t64", 1'b0, 2'd1, 64'h0, 64'h0, 2'd1, 1'b0);
        set_cfg(2'd1, 1'b0, 1'b0, 64'h0030_0000, 64'h0, 64'h100);
        access("R7 no redirect nonsec", 1'b0, 2'd1, 64'h0, 64'h0, 2'd1, 1'b0);
    endtask

    task automatic t_lvl2;
        set_cfg(2'd2, 1'b0, 1'b1, 64'h0033_0000, 64'h100, 64'h100);
        access("R8 vec bit", 1'b0, 2'd2, 64'h0, 64'h0, 2'd2, 1'b0);
        set_cfg(2'd1, 1'b0, 1'b1, 64'h0033_0000, 64'h400, 64'h100);
        access("R8 fp bit lvl1", 1'b0, 2'd1, 64'h0, 64'h0, 2'd2, 1'b0);
        set_cfg(2'd2, 1'b1, 1'b1, 64'h0033_0000, 64'h500, 64'h100);
        access("R8 secure skip", 1'b0, 2'd2, 64'h0, 64'hA, 2'd0, 1'b0);
        set_cfg(2'd3, 1'b0, 1'b1, 64'h0033_0000, 64'h500, 64'h100);
        access("R8 lvl3 skip", 1'b0, 2'd1, 64'h0, 64'h5, 2'd0, 1'b0);
    endtask

    task automatic t_lvl3;
        set_cfg(2'd3, 1'b0, 1'b1, 64'h0033_0000, 64'h0, 64'h0);
        access("R9 enable clear", 1'b0, 2'd3, 64'h0, 64'h0, 2'd3, 1'b0);
        set_cfg(2'd2, 1'b0, 1'b1, 64'h0033_0000, 64'h0, 64'h500);
        access("R9 fp trap set", 1'b0, 2'd2, 64'h0, 64'h0, 2'd3, 1'b0);
    endtask

    task automatic t_order;
        set_cfg(2'd1, 1'b0, 1'b1, 64'h0000_0000, 64'h500, 64'h400);
        access("R10 field first", 1'b0, 2'd1, 64'h0, 64'h0, 2'd1, 1'b0);
        set_cfg(2'd2, 1'b0, 1'b1, 64'h0033_0000, 64'h100, 64'h0);
        access("R10 lvl2 before lvl3", 1'b0, 2'd2, 64'h0, 64'h0, 2'd2, 1'b0);
    endtask

    task automatic t_blocked;
        set_cfg(2'd1, 1'b0, 1'b1, 64'h0030_0000, 64'h0, 64'h100);
        access("R11 trapped write", 1'b1, 2'd1, 64'h3, 64'h0, 2'd1, 1'b0);
        set_cfg(2'd2, 1'b0, 1'b1, 64'h0033_0000, 64'h0, 64'h0);
        access("R11 trapped write L2", 1'b1, 2'd2, 64'h1, 64'h0, 2'd3, 1'b0);
        set_cfg(2'd1, 1'b0, 1'b1, 64'h0033_0000, 64'h0, 64'h100);
        access("R11 undef write", 1'b1, 2'd2, 64'h2, 64'h0, 2'd0, 1'b1);
        set_cfg(2'd3, 1'b0, 1'b1, 64'h0033_0000, 64'h0, 64'h100);
        access("R11 L1 kept", 1'b0, 2'd1, 64'h0, 64'h5, 2'd0, 1'b0);
        access("R11 L2 kept", 1'b0, 2'd2, 64'h0, 64'hA, 2'd0, 1'b0);
    endtask

    task automatic t_priv;
        set_cfg(2'd0, 1'b0, 1'b1, 64'h0033_0000, 64'h0, 64'h100);
        access("R4 lvl0 L1", 1'b0, 2'd1, 64'h0, 64'h0, 2'd0, 1'b1);
        set_cfg(2'd2, 1'b0, 1'b1, 64'h0033_0000, 64'h0, 64'h100);
        access("R4 lvl2 L3", 1'b0, 2'd3, 64'h0, 64'h0, 2'd0, 1'b1);
        access("R4 sel 0", 1'b0, 2'd0, 64'h0, 64'h0, 2'd0, 1'b1);
        set_cfg(2'd1, 1'b0, 1'b1, 64'h0030_0000, 64'h0, 64'h0);
        access("R4 undef beats trap", 1'b0, 2'd2, 64'h0, 64'h0, 2'd0, 1'b1);
    endtask

    task automatic t_absent;
        has_lvl2 = 1'b0;
        set_cfg(2'd2, 1'b0, 1'b1, 64'h0000_0000, 64'h500, 64'h0);
        @(negedge clk);
        access("R12 read zero", 1'b0, 2'd2, 64'h0, 64'h0, 2'd0, 1'b0);
        access("R12 write ignored", 1'b1, 2'd2, 64'hF, 64'h0, 2'd0, 1'b0);
        set_cfg(2'd2, 1'b0, 1'b1, 64'h0033_0000, 64'h500, 64'h100);
        access("R12 no lvl2 trap", 1'b0, 2'd1, 64'h0, 64'h5, 2'd0, 1'b0);
        has_lvl3 = 1'b0;
        set_cfg(2'd3, 1'b0, 1'b1, 64'h0033_0000, 64'h0, 64'h0);
        @(negedge clk);
        access("R4 L3 absent", 1'b0, 2'd3, 64'h0, 64'h0, 2'd0, 1'b1);
        access("R9 absent lvl3 no trap", 1'b0, 2'd1, 64'h0, 64'h5, 2'd0, 1'b0);
        has_lvl2 = 1'b1; has_lvl3 = 1'b1;
        set_cfg(2'd3, 1'b0, 1'b1, 64'h0033_0000, 64'h0, 64'h100);
        @(negedge clk);
        access("R12 L2 kept after", 1'b0, 2'd2, 64'h0, 64'hA, 2'd0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_pre: check("R1 valid during reset", {63'd0, rsp_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask();
        t_fields();
        t_secure();
        t_lvl2();
        t_lvl3();
        t_order();
        t_blocked();
        t_priv();
        t_absent();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule